// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address stream for one bank access burst in a synchronous DRAM style memory controller. A read or write command delivers a bank number, a starting column, a burst-length code and an ordering bit. The block captures them. On each following clock it presents one column address together with the bank, a valid flag and a last-beat flag.

Bursts of fixed length keep the column bits above the burst field unchanged. The low bits of the column are ordered either by a wrapping count or by an XOR pattern. A full-page burst steps through the whole row, wrapping from the top column back to zero, and runs until a terminate strobe or a new command stops it. A new command is accepted on any clock. It always replaces the burst in progress.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, and whenever no burst is running, `valid` and `last` are 0.
- R2: A command sampled on a rising edge makes beat 0 appear right after that same edge: `valid`=1, `col_out` equal to the command's start column, and `bank_out` equal to the command's bank.
- R3: `bl_code` sets the burst length. 0 gives 1 beat, 1 gives 2 beats, 2 gives 4 beats and 3 gives 8 beats. Any code with bit 2 set selects full page.
- R4: With `burst_il`=0 and a fixed length BL, beat n carries the start column's low log2(BL) bits plus n, wrapped within the aligned block of BL columns. The upper bits are kept unchanged.
- R5: With `burst_il`=1 and a fixed length BL, the low log2(BL) bits of beat n equal the start low bits XOR n. The upper bits are kept unchanged.
- R6: In full-page mode beat n carries (start + n) mod 512, and `last` is never asserted.
- R7: In full-page mode `burst_il` is ignored and the order is the incrementing one of R6.
- R8: `last` is asserted only on the final beat of a fixed-length burst. On the clock after it, `valid` is 0 unless a command was sampled on that edge.
- R9: A burst length of 1 produces exactly one beat, with `valid` and `last` both 1.
- R10: A command arriving during a burst, including on the clock right after the previous command, aborts that burst. The new sequence starts from the new command's start column.
- R11: `term` sampled with no command ends the burst, so `valid` is 0 after that edge. If `cmd_valid` and `term` are sampled together, the command wins.
- R12: `bank_out` holds the captured bank for every beat of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Read or write command strobe |
| cmd_bank | input | 2 | Bank of the command |
| cmd_col | input | 9 | Start column of the command |
| bl_code | input | 3 | Burst-length code (see R3) |
| burst_il | input | 1 | 0 = incrementing order, 1 = XOR order |
| term | input | 1 | Burst-terminate strobe |
| col_out | output | 9 | Column address of the current beat |
| bank_out | output | 2 | Bank of the current beat |
| valid | output | 1 | A beat is presented this cycle |
| last | output | 1 | Final beat of a fixed-length burst |

## Verification
Some rules can be seen at the ports on every clock, and the assertions check these each cycle. A command always opens a beat. `last` never appears without `valid`. A last beat or a terminate with no command closes the burst. The bank stays steady while a burst continues. The address orderings depend on the mode held inside the block, so only the bench scenarios can show them. Those scenarios cover incrementing and XOR ordering with their wraps, full-page wrap past column 511, XOR ignored under full page, and aborts by back-to-back commands.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [2:0]        bl_code,
  input  logic              burst_il,
  input  logic              term,
  output logic [COL_W-1:0]  col_out,
  output logic [BANK_W-1:0] bank_out,
  output logic              valid,
  output logic              last
);

  logic [COL_W-1:0]  start_q, cnt_q, mask_q;
  logic [BANK_W-1:0] bank_q;
  logic              il_q, page_q, valid_q;
  logic [COL_W-1:0]  mask_d;

  assign mask_d = bl_code[2] ? '1 : COL_W'((1 << bl_code[1:0]) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      cnt_q   <= '0;
      mask_q  <= '0;
      bank_q  <= '0;
      il_q    <= 1'b0;
      page_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (cmd_valid) begin
      start_q <= cmd_col;
      cnt_q   <= '0;
      mask_q  <= mask_d;
      bank_q  <= cmd_bank;
      il_q    <= burst_il & ~bl_code[2];
      page_q  <= bl_code[2];
      valid_q <= 1'b1;
    end else if (valid_q) begin
      if (term || last) valid_q <= 1'b0;
      else              cnt_q   <= cnt_q + 1'b1;
    end
  end

  logic [COL_W-1:0] low_seq, low_il;
  assign low_seq = (start_q + cnt_q) & mask_q;
  assign low_il  = (start_q ^ cnt_q) & mask_q;

  assign col_out  = (start_q & ~mask_q) | (il_q ? low_il : low_seq);
  assign bank_out = bank_q;
  assign valid    = valid_q;
  assign last     = valid_q & ~page_q & (cnt_q == mask_q);

endmodule

module burst_col_gen_chk #(
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              term,
  input logic [BANK_W-1:0] bank_out,
  input logic              valid,
  input logic              last
);

  // R1
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !cmd_valid) |=> !valid);

  // R2
  cmd_opens_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> valid);

  // R8
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> valid);

  // R8
  last_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !cmd_valid) |=> !valid);

  // R11
  term_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term && !cmd_valid) |=> !valid);

  // R12
  bank_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !last && !term && !cmd_valid) |=> (valid && $stable(bank_out)));

endmodule

bind burst_col_gen burst_col_gen_chk #(.BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .term(term),
  .bank_out(bank_out), .valid(valid), .last(last)
);

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_bank = '0;
  logic [8:0] cmd_col = '0;
  logic [2:0] bl_code = '0;
  logic       burst_il = 1'b0;
  logic       term = 1'b0;
  logic [8:0] col_out;
  logic [1:0] bank_out;
  logic       valid, last;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  typedef struct {
    logic [8:0] col;
    logic [1:0] bank;
    logic       last;
    string      tag;
  } beat_t;
  beat_t exp_q[$];

  always #2.5 clk = ~clk;

  burst_col_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_bank(cmd_bank),
    .cmd_col(cmd_col), .bl_code(bl_code), .burst_il(burst_il), .term(term),
    .col_out(col_out), .bank_out(bank_out), .valid(valid), .last(last)
  );

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_col(logic [8:0] s, logic [2:0] code, bit il, int n);
    logic [8:0] m, nn;
    m  = code[2] ? 9'h1FF : 9'((1 << code[1:0]) - 1);
    nn = 9'(n);
    if (il && !code[2]) return (s & ~m) | ((s ^ nn) & m);
    return (s & ~m) | ((s + nn) & m);
  endfunction

  // Drive at posedge+1; returns at posedge+1 after the command is sampled.
  task automatic issue(logic [1:0] b, logic [8:0] c, logic [2:0] code, bit il,
                       int nbeats, bit with_term, string tag);
    int len;
    cmd_valid = 1; cmd_bank = b; cmd_col = c; bl_code = code; burst_il = il;
    term = with_term;
    @(posedge clk);
    exp_q.delete();
    len = code[2] ? nbeats : (1 << code[1:0]);
    for (int i = 0; i < len; i++) begin
      beat_t e;
      e.col = exp_col(c, code, il, i);
      e.bank = b;
      e.last = !code[2] && (i == len - 1);
      e.tag = tag;
      exp_q.push_back(e);
    end
    #1;
    cmd_valid = 0; term = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Let k beats through (beat 0 already shown), then terminate.
  task automatic stop_after(int k, string tag);
    repeat (k - 1) @(posedge clk);
    #1 term = 1;
    @(posedge clk);
    exp_q.delete();
    #1 term = 0;
    @(negedge clk);
    chk(valid == 0, tag, "valid after term", valid, 0);
    @(posedge clk); #1;
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (valid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R8", "unexpected beat col", col_out, 0);
        end else begin
          beat_t e;
          e = exp_q.pop_front();
          chk(col_out == e.col, e.tag, "col", col_out, e.col);
          chk(bank_out == e.bank, {e.tag, "/R12"}, "bank", bank_out, e.bank);
          chk(last == e.last, {e.tag, "/R8"}, "last", last, e.last);
        end
      end else if (exp_q.size() != 0) begin
        chk(0, exp_q[0].tag, "missing beat col", 0, exp_q[0].col);
        exp_q.delete();
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(valid == 0, "R1", "valid in reset", valid, 0);
    chk(last == 0, "R1", "last in reset", last, 0);
    rst_n = 1;
    idle(2);
    chk(valid == 0, "R1", "valid idle", valid, 0);

    // R9 R3 R2 single beat
    issue(2'd2, 9'h1A5, 3'd0, 0, 0, 0, "R9"); idle(3);
    // R4 incrementing order, wraps in aligned block
    issue(2'd1, 9'h0F3, 3'd1, 0, 0, 0, "R4"); idle(4);
    issue(2'd3, 9'h106, 3'd2, 0, 0, 0, "R4"); idle(6);
    issue(2'd0, 9'h05D, 3'd3, 0, 0, 0, "R4"); idle(10);
    // R5 XOR order
    issue(2'd1, 9'h0A2, 3'd2, 1, 0, 0, "R5"); idle(6);
    issue(2'd2, 9'h1F5, 3'd3, 1, 0, 0, "R5"); idle(10);
    issue(2'd3, 9'h011, 3'd1, 1, 0, 0, "R5"); idle(4);
    // R6 full page wraps past 511
    issue(2'd2, 9'h1FB, 3'd7, 0, 520, 0, "R6"); stop_after(520, "R6");
    // R7 XOR ignored in full page
    issue(2'd1, 9'h10A, 3'd7, 1, 20, 0, "R7"); stop_after(20, "R7");
    // R3 other codes with bit 2 select full page
    issue(2'd0, 9'h003, 3'd5, 0, 12, 0, "R3"); stop_after(12, "R3");
    // R10 back-to-back commands
    issue(2'd0, 9'h040, 3'd3, 0, 0, 0, "R10");
    issue(2'd1, 9'h083, 3'd2, 1, 0, 0, "R10"); idle(6);
    // R10 abort mid-burst
    issue(2'd3, 9'h120, 3'd3, 0, 0, 0, "R10"); idle(3);
    issue(2'd2, 9'h0FF, 3'd3, 0, 0, 0, "R10"); idle(10);
    // R11 terminate a fixed burst
    issue(2'd1, 9'h038, 3'd3, 1, 0, 0, "R11"); stop_after(3, "R11");
    // R11 command wins over terminate
    issue(2'd3, 9'h150, 3'd2, 0, 0, 0, "R11");
    issue(2'd0, 9'h0C9, 3'd2, 0, 0, 1, "R11"); idle(6);
    chk(valid == 0, "R8", "valid after burst", valid, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule